// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block turns one host configuration request (bus, slot, function, register, transfer size and write data) into a short series of cycles on a downstream register bus. First it writes a configuration address word into the bridge's address register. Then it reads that register back, and it rewrites the register until the value read back equals the value it intended. Only after that does it move data through the bridge's data window. The host sees a valid/ready request port and a one-cycle completion pulse that carries read data and an error flag.

The input `gen_ext` selects one of two bridge generations. The legacy generation reaches devices on its own root bus with a one-hot device-select encoding (type 0) and refuses slots below 11 there. The extended generation always issues type 1 words and carries register bits 11:8 in the top nibble of the address word. A configurable skip slot is refused on every bus. A refused read completes with all ones, and a refused write disappears, in both cases without any bus cycle. When the readback never matches within `MAX_TRIES` attempts, the request ends with an error.

States: `ST_IDLE` (waiting for a request), `ST_ADDR_WRITE` (address word write), `ST_ADDR_READ` (address readback), `ST_DATA` (data window access) and `ST_DONE` (one-cycle completion).
Transitions:
- accept-and-refuse: `ST_IDLE`→`ST_DONE`
- accept: `ST_IDLE`→`ST_ADDR_WRITE`
- written: `ST_ADDR_WRITE`→`ST_ADDR_READ`
- matched: `ST_ADDR_READ`→`ST_DATA`
- matched-no-size: `ST_ADDR_READ`→`ST_DONE`
- retry: `ST_ADDR_READ`→`ST_ADDR_WRITE`
- exhausted: `ST_ADDR_READ`→`ST_DONE`
- moved: `ST_DATA`→`ST_DONE`
- complete: `ST_DONE`→`ST_IDLE`

Top module: `cfg_access_seq`

## Requirements
- R1: `req_ready` is high only in the idle state. Each accepted request produces exactly one `done` pulse, which is one cycle wide, and `req_ready` stays low from acceptance until after that pulse.
- R2: On the legacy generation (`gen_ext`=0), when `req_bus` equals `root_bus`, the address word is a single set bit at position slot, OR func<<8, OR reg[7:2]<<2, with bit 0 clear.
- R3: For any other bus, and for every access when `gen_ext`=1, the address word is bus<<16 | slot<<11 | func<<8 | reg[7:2]<<2 | 1.
- R4: When `gen_ext`=1, reg[11:8] appears in address word bits 31:28. On the legacy generation these register bits are ignored.
- R5: On the legacy generation, a root-bus request with slot below 11 is refused without a bus cycle. A refused read returns 0xFFFFFFFF with `done_err`=0.
- R6: When `skip_en`=1, a request whose slot equals `skip_slot` is refused without a bus cycle on any bus. A refused write leaves the data window unchanged.
- R7: The address word is written to bus offset 0x800000 (byte enables 1111), then read back from the same offset. A mismatch causes a rewrite, and no data-window cycle happens before a readback matches.
- R8: After `MAX_TRIES` (default 4) mismatching readbacks, the request completes with `done_err`=1, `done_rdata`=0xFFFFFFFF and no data cycle. A match on the last allowed readback completes normally.
- R9: The data cycle goes to 0xC00000 + aligned reg[2:0]. Size code 0 selects a byte at lane reg[1:0]; code 1 selects a halfword at lanes {reg[1],0}+1..{reg[1],0}; code 2 selects a word at offset reg[2]*4. Lane 0 carries the least significant byte; read data is right-aligned and write data comes from the low bits.
- R10: Size code 3 performs the address write and readback but no data cycle. A read then returns 0xFFFFFFFF with `done_err`=0.
- R11: While `bus_valid` is high and `bus_ack` is low, `bus_valid`, `bus_write` and `bus_addr` hold their values into the next cycle.
- R12: After reset the sequencer is idle with `req_ready`=1, `bus_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_ext | input | 1 | 1 selects the extended-register generation |
| root_bus | input | 8 | Number of the bridge's own bus |
| skip_en | input | 1 | Enables the skip-slot filter |
| skip_slot | input | 5 | Slot refused when the filter is enabled |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus |
| req_slot | input | 5 | Target slot |
| req_func | input | 3 | Target function |
| req_reg | input | 12 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 no data phase |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Read result, valid with done |
| done_err | output | 1 | Readback retry limit reached |
| bus_valid | output | 1 | Downstream cycle request |
| bus_write | output | 1 | Downstream write |
| bus_addr | output | 24 | Byte offset from the bridge base |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Downstream write data |
| bus_rdata | input | 32 | Downstream read data, valid with ack |
| bus_ack | input | 1 | Cycle complete |

## Verification
The readback compare and the retry-limit decision fall in the same cycle, on the acknowledge of the last allowed readback. If the limit test took priority over the compare, a late match would wrongly end in an error. The bench provokes this by corrupting exactly `MAX_TRIES`-1 readbacks and expects a normal completion after nine bus cycles. It then corrupts `MAX_TRIES` readbacks and expects the error result with eight bus cycles and no data-window access. Stretched acknowledges run during these retries so that the address is held while the compare is pending.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
    localparam int BUS_W   = 8;
    localparam int SLOT_W  = 5;
    localparam int FUNC_W  = 3;
    localparam int REG_W   = 12;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int BADDR_W = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_WRITE,
        ST_ADDR_READ,
        ST_DATA,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } xfer_size_t;

    typedef struct packed {
        logic              write;
        logic [REG_W-1:0]  regn;
        xfer_size_t        size;
        logic [WORD_W-1:0] wdata;
    } cfg_req_t;
endpackage

// File: rtl/cfgseq_addr_enc.sv
module cfgseq_addr_enc
    import cfgseq_pkg::*;
#(
    parameter int unsigned MIN_ROOT_SLOT = 11
) (
    input  logic              gen_ext,
    input  logic [BUS_W-1:0]  root_bus,
    input  logic              skip_en,
    input  logic [SLOT_W-1:0] skip_slot,
    input  logic [BUS_W-1:0]  bus,
    input  logic [SLOT_W-1:0] slot,
    input  logic [FUNC_W-1:0] func,
    input  logic [REG_W-1:0]  regn,
    output logic [WORD_W-1:0] addr_word,
    output logic              reject
);
    logic is_local;
    logic skip_hit;
    logic low_slot;

    always_comb begin
        is_local = (bus == root_bus) && !gen_ext;
        if (is_local) begin
            addr_word = (WORD_W'(1) << slot)
                      | (WORD_W'(func) << 8)
                      | {{(WORD_W-8){1'b0}}, regn[7:2], 2'b00};
        end else begin
            addr_word = (WORD_W'(bus) << 16)
                      | (WORD_W'(slot) << 11)
                      | (WORD_W'(func) << 8)
                      | {{(WORD_W-8){1'b0}}, regn[7:2], 2'b01};
        end
        if (gen_ext) begin
            addr_word[WORD_W-1 -: 4] = regn[11:8];
        end
        skip_hit = skip_en && (slot == skip_slot);
        low_slot = is_local && (32'(slot) < MIN_ROOT_SLOT);
        reject   = skip_hit || low_slot;
    end
endmodule

// File: rtl/cfgseq_lane_steer.sv
module cfgseq_lane_steer
    import cfgseq_pkg::*;
(
    input  xfer_size_t        size,
    input  logic [2:0]        off,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [2:0]        aligned_off,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] host_rdata
);
    logic [WORD_W-1:0] mask;
    logic [4:0]        sh;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                aligned_off = off;
                mask        = 32'h0000_00FF;
                be          = LANES'(4'b0001) << off[1:0];
            end
            SZ_HALF: begin
                aligned_off = {off[2:1], 1'b0};
                mask        = 32'h0000_FFFF;
                be          = LANES'(4'b0011) << {off[1], 1'b0};
            end
            default: begin
                aligned_off = {off[2], 2'b00};
                mask        = 32'hFFFF_FFFF;
                be          = {LANES{1'b1}};
            end
        endcase
        sh         = {aligned_off[1:0], 3'b000};
        bus_wdata  = (host_wdata & mask) << sh;
        host_rdata = (bus_rdata >> sh) & mask;
    end
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
    import cfgseq_pkg::*;
#(
    parameter logic [23:0] ADDR_OFF      = 24'h80_0000,
    parameter logic [23:0] DATA_OFF      = 24'hC0_0000,
    parameter int unsigned MAX_TRIES     = 4,
    parameter int unsigned MIN_ROOT_SLOT = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gen_ext,
    input  logic [7:0]  root_bus,
    input  logic        skip_en,
    input  logic [4:0]  skip_slot,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_slot,
    input  logic [2:0]  req_func,
    input  logic [11:0] req_reg,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        done,
    output logic [31:0] done_rdata,
    output logic        done_err,
    output logic        bus_valid,
    output logic        bus_write,
    output logic [23:0] bus_addr,
    output logic [3:0]  bus_be,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [WORD_W-1:0] ALL_ONES = '1;

    seq_state_t        state, state_nx;
    cfg_req_t          cur;
    logic [WORD_W-1:0] want_word;
    logic [TRY_W-1:0]  misses;
    logic [WORD_W-1:0] res_data;
    logic              res_err;

    logic [WORD_W-1:0] enc_word;
    logic              enc_reject;
    logic [2:0]        lane_off;
    logic [LANES-1:0]  lane_be;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] lane_rdata;

    logic accept;
    logic rb_match;
    logic last_try;

    cfgseq_addr_enc #(.MIN_ROOT_SLOT(MIN_ROOT_SLOT)) u_enc (
        .gen_ext   (gen_ext),
        .root_bus  (root_bus),
        .skip_en   (skip_en),
        .skip_slot (skip_slot),
        .bus       (req_bus),
        .slot      (req_slot),
        .func      (req_func),
        .regn      (req_reg),
        .addr_word (enc_word),
        .reject    (enc_reject)
    );

    cfgseq_lane_steer u_lane (
        .size        (cur.size),
        .off         (cur.regn[2:0]),
        .host_wdata  (cur.wdata),
        .bus_rdata   (bus_rdata),
        .aligned_off (lane_off),
        .be          (lane_be),
        .bus_wdata   (lane_wdata),
        .host_rdata  (lane_rdata)
    );

    assign accept   = req_valid && (state == ST_IDLE);
    assign rb_match = (bus_rdata == want_word);
    assign last_try = (32'(misses) + 1 >= MAX_TRIES);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) state_nx = enc_reject ? ST_DONE : ST_ADDR_WRITE;
            end
            ST_ADDR_WRITE: begin
                if (bus_ack) state_nx = ST_ADDR_READ;
            end
            ST_ADDR_READ: begin
                if (bus_ack) begin
                    if (rb_match)      state_nx = (cur.size == SZ_NONE) ? ST_DONE : ST_DATA;
                    else if (last_try) state_nx = ST_DONE;
                    else               state_nx = ST_ADDR_WRITE;
                end
            end
            ST_DATA: begin
                if (bus_ack) state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // request latch and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur       <= '0;
            want_word <= '0;
            misses    <= '0;
            res_data  <= '0;
            res_err   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur.write <= req_write;
                        cur.regn  <= req_reg;
                        cur.size  <= xfer_size_t'(req_size);
                        cur.wdata <= req_wdata;
                        want_word <= enc_word;
                        misses    <= '0;
                        res_err   <= 1'b0;
                        res_data  <= (enc_reject && !req_write) ? ALL_ONES : '0;
                    end
                end
                ST_ADDR_READ: begin
                    if (bus_ack) begin
                        if (rb_match) begin
                            if (cur.size == SZ_NONE && !cur.write) res_data <= ALL_ONES;
                        end else begin
                            misses <= misses + 1'b1;
                            if (last_try) begin
                                res_err  <= 1'b1;
                                res_data <= ALL_ONES;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (bus_ack && !cur.write) res_data <= lane_rdata;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        done       = (state == ST_DONE);
        done_rdata = res_data;
        done_err   = res_err;
        bus_valid  = 1'b0;
        bus_write  = 1'b0;
        bus_addr   = ADDR_OFF;
        bus_be     = {LANES{1'b1}};
        bus_wdata  = '0;
        unique case (state)
            ST_ADDR_WRITE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = want_word;
            end
            ST_ADDR_READ: begin
                bus_valid = 1'b1;
            end
            ST_DATA: begin
                bus_valid = 1'b1;
                bus_write = cur.write;
                bus_addr  = DATA_OFF + {21'b0, lane_off};
                bus_be    = lane_be;
                bus_wdata = cur.write ? lane_wdata : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker #(
    parameter logic [23:0] ADDR_OFF  = 24'h80_0000,
    parameter logic [23:0] DATA_OFF  = 24'hC0_0000,
    parameter int unsigned MAX_TRIES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic [31:0] done_rdata,
    input logic        done_err,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [23:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_ack
);
    logic [31:0] seen_word;
    logic        matched;
    logic [7:0]  mism;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_word <= '0;
            matched   <= 1'b0;
            mism      <= '0;
        end else if (req_valid && req_ready) begin
            matched <= 1'b0;
            mism    <= '0;
        end else if (bus_valid && bus_ack && bus_addr == ADDR_OFF) begin
            if (bus_write) begin
                seen_word <= bus_wdata;
                matched   <= 1'b0;
            end else begin
                matched <= (bus_rdata == seen_word);
                if (bus_rdata != seen_word) mism <= mism + 8'd1;
            end
        end
    end

    assert_single_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);
    assert_data_after_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr != ADDR_OFF) |-> matched);
    assert_retry_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> (32'(mism) == MAX_TRIES && done_rdata == 32'hFFFF_FFFF));
    assert_tries_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(mism) <= MAX_TRIES);
    assert_data_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr != ADDR_OFF) |-> (bus_addr[23:3] == DATA_OFF[23:3]));
    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));
endmodule

bind cfg_access_seq cfgseq_checker #(
    .ADDR_OFF  (ADDR_OFF),
    .DATA_OFF  (DATA_OFF),
    .MAX_TRIES (MAX_TRIES)
) u_chk (.*);

// File: tb/tb_cfg_access_seq.sv
module tb_cfg_access_seq;
    localparam logic [23:0] A_OFF = 24'h80_0000;
    localparam int TRIES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        gen_ext = 0, skip_en = 0;
    logic [7:0]  root_bus = 0;
    logic [4:0]  skip_slot = 0;
    logic        req_valid = 0, req_write = 0;
    logic        req_ready;
    logic [7:0]  req_bus = 0;
    logic [4:0]  req_slot = 0;
    logic [2:0]  req_func = 0;
    logic [11:0] req_reg = 0;
    logic [1:0]  req_size = 0;
    logic [31:0] req_wdata = 0;
    logic        done, done_err;
    logic [31:0] done_rdata;
    logic        bus_valid, bus_write, bus_ack;
    logic [23:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;

    cfg_access_seq dut (.*);

    // downstream model
    logic [7:0]  win [0:7];
    logic [31:0] areg = 0;
    int          corrupt_left = 0;
    logic        stall_en = 0, ph = 0;
    int          n_bus = 0, n_data = 0;
    logic [31:0] last_aw = 0;

    always @(posedge clk) ph <= ~ph;
    assign bus_ack = bus_valid && (!stall_en || ph);

    always_comb begin
        if (bus_addr == A_OFF)
            bus_rdata = areg ^ ((corrupt_left > 0) ? 32'h1 : 32'h0);
        else
            bus_rdata = {win[{bus_addr[2], 2'd3}], win[{bus_addr[2], 2'd2}],
                         win[{bus_addr[2], 2'd1}], win[{bus_addr[2], 2'd0}]};
    end

    always @(posedge clk) begin
        if (bus_valid && bus_ack) begin
            n_bus <= n_bus + 1;
            if (bus_addr == A_OFF) begin
                if (bus_write) begin areg <= bus_wdata; last_aw <= bus_wdata; end
                else if (corrupt_left > 0) corrupt_left <= corrupt_left - 1;
            end else begin
                n_data <= n_data + 1;
                if (bus_write)
                    for (int k = 0; k < 4; k++)
                        if (bus_be[k]) win[{bus_addr[2], k[1:0]}] <= bus_wdata[8*k +: 8];
            end
        end
    end

    // completion monitor
    int          done_cnt = 0;
    logic [31:0] got_data = 0;
    logic        got_err = 0;
    always @(negedge clk) begin
        if (done) begin
            done_cnt <= done_cnt + 1;
            got_data <= done_rdata;
            got_err  <= done_err;
        end
    end

    int checks = 0, fails = 0;
    logic finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] b, input logic [4:0] s,
                          input logic [2:0] f, input logic [11:0] r,
                          input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        n_bus = 0; n_data = 0; done_cnt = 0;
        req_write = wr; req_bus = b; req_slot = s; req_func = f;
        req_reg = r; req_size = sz; req_wdata = wd; req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R1 busy after accept", 32'(req_ready), 0);
        for (int i = 0; i < 200 && done_cnt == 0; i++) @(negedge clk);
        @(negedge clk);
        chk(done_cnt == 1, "R1 one done pulse", done_cnt, 1);
        chk(req_ready == 1, "R1 ready after done", 32'(req_ready), 1);
    endtask

    task automatic t_reset;
        chk(req_ready == 1, "R12 ready", 32'(req_ready), 1);
        chk(bus_valid == 0, "R12 bus idle", 32'(bus_valid), 0);
        chk(done == 0, "R12 no done", 32'(done), 0);
    endtask

    task automatic t_type0;
        gen_ext = 0; root_bus = 0;
        access(0, 8'd0, 5'd12, 3'd3, 12'h046, 2'd2, 0);
        chk(last_aw == 32'h0000_1344, "R2 type0 word", last_aw, 32'h0000_1344);
        chk(got_data == 32'h1716_1514, "R9 word read", got_data, 32'h1716_1514);
        chk(n_bus == 3, "R7 three cycles", n_bus, 3);
    endtask

    task automatic t_type1;
        access(0, 8'd5, 5'd2, 3'd1, 12'h310, 2'd2, 0);
        chk(last_aw == 32'h0005_1111, "R3 type1 word, R4 legacy ignores high reg", last_aw, 32'h0005_1111);
        chk(got_data == 32'h1312_1110, "R9 word read off0", got_data, 32'h1312_1110);
    endtask

    task automatic t_ext;
        gen_ext = 1;
        access(0, 8'd0, 5'd0, 3'd0, 12'h1A8, 2'd0, 0);
        chk(last_aw == 32'h1000_00A9, "R4 ext word", last_aw, 32'h1000_00A9);
        chk(got_data == 32'h10, "R9 byte read", got_data, 32'h10);
        gen_ext = 0;
    endtask

    task automatic t_low_slot;
        access(0, 8'd0, 5'd5, 3'd0, 12'h000, 2'd2, 0);
        chk(got_data == 32'hFFFF_FFFF, "R5 refused read ones", got_data, 32'hFFFF_FFFF);
        chk(n_bus == 0, "R5 no bus cycle", n_bus, 0);
        chk(got_err == 0, "R5 no error", 32'(got_err), 0);
    endtask

    task automatic t_skip;
        skip_en = 1; skip_slot = 5'd20;
        access(1, 8'd3, 5'd20, 3'd0, 12'h000, 2'd0, 32'hEE);
        chk(n_bus == 0, "R6 skipped write no cycle", n_bus, 0);
        skip_en = 0;
        access(0, 8'd0, 5'd12, 3'd0, 12'h000, 2'd0, 0);
        chk(got_data == 32'h10, "R6 window unchanged", got_data, 32'h10);
    endtask

    task automatic t_lanes;
        access(1, 8'd0, 5'd12, 3'd0, 12'h005, 2'd0, 32'hFFFF_FFAB);
        access(0, 8'd0, 5'd12, 3'd0, 12'h004, 2'd2, 0);
        chk(got_data == 32'h1716_AB14, "R9 byte write lane1", got_data, 32'h1716_AB14);
        access(1, 8'd0, 5'd12, 3'd0, 12'h002, 2'd1, 32'h1234_BEEF);
        access(0, 8'd0, 5'd12, 3'd0, 12'h000, 2'd2, 0);
        chk(got_data == 32'hBEEF_1110, "R9 half write upper", got_data, 32'hBEEF_1110);
        access(0, 8'd0, 5'd12, 3'd0, 12'h006, 2'd1, 0);
        chk(got_data == 32'h0000_1716, "R9 half read", got_data, 32'h0000_1716);
        access(0, 8'd0, 5'd12, 3'd0, 12'h003, 2'd0, 0);
        chk(got_data == 32'h0000_00BE, "R9 byte read lane3", got_data, 32'h0000_00BE);
    endtask

    task automatic t_retry;
        stall_en = 1; corrupt_left = 2;
        access(0, 8'd0, 5'd12, 3'd0, 12'h004, 2'd2, 0);
        chk(n_bus == 7, "R7 two rewrites", n_bus, 7);
        chk(got_data == 32'h1716_AB14, "R7 data after match", got_data, 32'h1716_AB14);
        corrupt_left = TRIES - 1;
        access(0, 8'd0, 5'd12, 3'd0, 12'h004, 2'd2, 0);
        chk(n_bus == 9 && got_err == 0, "R8 match on last try", n_bus, 9);
        corrupt_left = TRIES;
        access(0, 8'd0, 5'd12, 3'd0, 12'h004, 2'd2, 0);
        chk(got_err == 1, "R8 error flag", 32'(got_err), 1);
        chk(got_data == 32'hFFFF_FFFF, "R8 ones", got_data, 32'hFFFF_FFFF);
        chk(n_bus == 8 && n_data == 0, "R8 no data cycle", n_bus, 8);
        stall_en = 0;
    endtask

    task automatic t_nosize;
        access(0, 8'd0, 5'd12, 3'd0, 12'h000, 2'd3, 0);
        chk(n_bus == 2, "R10 address only", n_bus, 2);
        chk(got_data == 32'hFFFF_FFFF && got_err == 0, "R10 ones", got_data, 32'hFFFF_FFFF);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) win[i] = 8'h10 + 8'(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_type0();
        t_type1();
        t_ext();
        t_low_slot();
        t_skip();
        t_lanes();
        t_retry();
        t_nosize();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule